// File: doc/BRIEF.md
# Periodic System Tick Timer

This block is a 24-bit down-counting timer that produces a regular time base for a processor core. Software programs a reload value and enables the counter. From then on the count falls by one on every tick and rests for one tick at zero. On the following tick it takes the reload value again. Each arrival at zero sets a sticky status flag. If interrupts are enabled, each arrival at zero also raises a one-cycle interrupt request.

Ticks come from one of two sources, chosen by a control bit. The first is the core clock itself, which gives one tick per cycle. The second is a slow external tick input. That input is passed through a synchroniser, and each rising edge becomes a single-cycle tick. A debug-halt input freezes the count while the core is stopped.

The timer has four word registers on a simple single-cycle register bus: control/status, reload, current value and a read-only calibration word. Reads are combinational. Writes take effect at the clock edge.

Top module: `tick_timer`

## Requirements
- R1: After reset, control/status reads 0x00000004, and the reload and current-value registers read 0.
- R2: A write to control/status that changes the enable bit (bit 0) from 0 to 1 loads the reload value into the counter at that clock edge. Counting starts on the ticks after that edge.
- R3: While enabled, each tick lowers a nonzero count by one. A tick that finds the count at zero loads the reload value.
- R4: The flag is bit 16 of control/status. It is set at the edge where the count goes from 1 to 0. A read of control/status returns the flag and clears it. If a new zero arrival happens in the same cycle as the read, the flag stays set.
- R5: The irq output is high for exactly one cycle. That cycle is the one after the edge that brings the count to zero, and irq rises only when the interrupt-enable bit (bit 1) is 1. With bit 1 at 0 the flag is still set.
- R6: While dbg_halt is high, the count does not change.
- R7: The source bit (bit 2) selects the tick. With 1, the counter advances on every core-clock cycle. With 0, ext_tick is used: a level first sampled high at edge k, after a low sample at edge k-1, advances the count at edge k+2.
- R8: Any write to the current-value register clears the count to 0 and clears the flag.
- R9: Writes to bits 31:24 of the reload and current-value registers have no effect, and those bits read 0. All control/status bits other than 16, 2, 1 and 0 read 0.
- R10: With a reload value of 0, a count at zero stays at zero and the flag is never set.
- R11: The calibration register reads 0x000F423F, and writes to it have no effect.
- R12: The registers are selected by address bits 3:2: control/status at 0x0, reload at 0x4, current value at 0x8 and calibration at 0xC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle, 0 when not reading |
| ext_tick | input | 1 | Asynchronous slow tick source |
| dbg_halt | input | 1 | Freezes counting while high |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
Read data depends only on the state before the edge, so the bench checks it a quarter period after driving the access, within the same cycle. Every write, zero arrival and flag change is visible from the first read after the following edge. The irq pulse belongs to the edge that brings the count to zero, so the bench compares irq at each falling edge against a model that it steps once per rising edge. An external tick edge moves the count two edges after it is first sampled, and the model tracks that delay with its own record of past input samples.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int TT_DATA_W = 32;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_LOAD  = 2'd1,
    REG_VAL   = 2'd2,
    REG_CALIB = 2'd3
  } tt_reg_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 16;

  typedef struct packed {
    logic use_core;
    logic irq_en;
    logic run;
  } tt_ctrl_t;

  localparam tt_ctrl_t CTRL_RESET = '{use_core: 1'b1, irq_en: 1'b0, run: 1'b0};

  function automatic logic [TT_DATA_W-1:0] pack_status(tt_ctrl_t c, logic flag);
    logic [TT_DATA_W-1:0] w;
    w = '0;
    w[CTRL_RUN_BIT]  = c.run;
    w[CTRL_IE_BIT]   = c.irq_en;
    w[CTRL_SRC_BIT]  = c.use_core;
    w[CTRL_FLAG_BIT] = flag;
    return w;
  endfunction

  function automatic tt_ctrl_t unpack_ctrl(logic [TT_DATA_W-1:0] w);
    tt_ctrl_t c;
    c.run      = w[CTRL_RUN_BIT];
    c.irq_en   = w[CTRL_IE_BIT];
    c.use_core = w[CTRL_SRC_BIT];
    return c;
  endfunction
endpackage

// File: rtl/tt_tick_src.sv
module tt_tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_tick,
  input  logic use_core,
  output logic tick
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      for (int i = 0; i < SYNC_STAGES; i++) begin
        if (i == 0) sync_q[i] <= ext_tick;
        else        sync_q[i] <= sync_q[i-1];
      end
      last_q <= sync_q[LAST];
    end
  end

  assign ext_rise = sync_q[LAST] & ~last_q;
  assign tick     = use_core | ext_rise;

  // R7
  ext_rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
endmodule

// File: rtl/tt_down_counter.sv
module tt_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             halt,
  input  logic             start,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             adv,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step_count(logic [CNT_W-1:0] c, logic [CNT_W-1:0] r);
    return (c == '0) ? r : c - ONE;
  endfunction

  logic [CNT_W-1:0] cnt_d;

  assign adv      = run & tick & ~halt;
  assign zero_evt = adv & ~clear & (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (start)      cnt_d = reload;
    else if (clear) cnt_d = '0;
    else if (adv)   cnt_d = step_count(cnt_q, reload);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == $past(reload));
  // R3
  dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !start && !clear && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
  // R6
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !start && !clear) |=> $stable(cnt_q));
  // R10
  zero_reload_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && reload == '0 && !start) |=> cnt_q == '0);
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int                 CNT_W       = 24,
  parameter int                 ADDR_W      = 4,
  parameter logic [TT_DATA_W-1:0] CALIB_VALUE = 32'h000F_423F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [TT_DATA_W-1:0] bus_wdata,
  output logic [TT_DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]     cnt_q,
  input  logic                 zero_evt,
  output tt_ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]     reload_q,
  output logic                 start,
  output logic                 clear,
  output logic                 flag_q,
  output logic                 irq_q
);
  localparam int PAD_W = TT_DATA_W - CNT_W;

  tt_reg_e idx;
  logic    rd, wr, wr_ctrl, rd_ctrl, wr_load;

  assign idx     = tt_reg_e'(bus_addr[3:2]);
  assign rd      = bus_sel & ~bus_wr;
  assign wr      = bus_sel & bus_wr;
  assign wr_ctrl = wr & (idx == REG_CTRL);
  assign rd_ctrl = rd & (idx == REG_CTRL);
  assign wr_load = wr & (idx == REG_LOAD);
  assign clear   = wr & (idx == REG_VAL);
  assign start   = wr_ctrl & bus_wdata[CTRL_RUN_BIT] & ~ctrl_q.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      reload_q <= '0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= unpack_ctrl(bus_wdata);
      if (wr_load) reload_q <= bus_wdata[CNT_W-1:0];
      if (zero_evt)              flag_q <= 1'b1;
      else if (rd_ctrl || clear) flag_q <= 1'b0;
      irq_q <= zero_evt & ctrl_q.irq_en;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (idx)
        REG_CTRL:  bus_rdata = pack_status(ctrl_q, flag_q);
        REG_LOAD:  bus_rdata = {{PAD_W{1'b0}}, reload_q};
        REG_VAL:   bus_rdata = {{PAD_W{1'b0}}, cnt_q};
        REG_CALIB: bus_rdata = CALIB_VALUE;
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> flag_q);
  // R5
  irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> flag_q);
  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R8
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !flag_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int                   CNT_W       = 24,
  parameter int                   ADDR_W      = 4,
  parameter int                   SYNC_STAGES = 2,
  parameter logic [TT_DATA_W-1:0] CALIB_VALUE = 32'h000F_423F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [TT_DATA_W-1:0] bus_wdata,
  output logic [TT_DATA_W-1:0] bus_rdata,
  input  logic                 ext_tick,
  input  logic                 dbg_halt,
  output logic                 irq
);
  tt_ctrl_t         ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick, adv, zero_evt, start, clear, flag_q, irq_q;

  tt_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_tick (ext_tick),
    .use_core (ctrl_q.use_core),
    .tick     (tick)
  );

  tt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q.run),
    .tick     (tick),
    .halt     (dbg_halt),
    .start    (start),
    .clear    (clear),
    .reload   (reload_q),
    .cnt_q    (cnt_q),
    .adv      (adv),
    .zero_evt (zero_evt)
  );

  tt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CALIB_VALUE(CALIB_VALUE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_q     (cnt_q),
    .zero_evt  (zero_evt),
    .ctrl_q    (ctrl_q),
    .reload_q  (reload_q),
    .start     (start),
    .clear     (clear),
    .flag_q    (flag_q),
    .irq_q     (irq_q)
  );

  assign irq = irq_q;

  // R5
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !ctrl_q.irq_en) |=> !irq);
  // R6
  halt_no_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt |-> !adv);
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_tick = 1'b0, dbg_halt = 1'b0;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  logic        m_run, m_ie, m_core, m_flag, m_irq;
  logic [23:0] m_cnt, m_reload;
  logic        e1, e2, e3;

  tick_timer i_tick_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_tick(ext_tick), .dbg_halt(dbg_halt), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_read(logic [3:0] a);
    case (a[3:2])
      2'd0:    return {15'd0, m_flag, 13'd0, m_core, m_ie, m_run};
      2'd1:    return {8'd0, m_reload};
      2'd2:    return {8'd0, m_cnt};
      default: return 32'h000F423F;
    endcase
  endfunction

  function automatic logic [23:0] exp_step(logic [23:0] c, logic [23:0] r);
    if (c == 24'd0) return r;
    return c - 24'd1;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_ie = 0; m_core = 1; m_flag = 0; m_irq = 0;
    m_cnt = '0; m_reload = '0; e1 = 0; e2 = 0; e3 = 0;
  endtask

  // one bus cycle; entered just after a falling edge
  task automatic cyc(logic sel, logic wr, logic [3:0] a, logic [31:0] wd,
                     logic ext, logic halt, string tag);
    logic tk, adv, wctrl, rctrl, wval, wload, start, zero;
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    ext_tick = ext; dbg_halt = halt;
    #(CLK_PERIOD/4);
    if (sel && !wr) check(tag, bus_rdata, exp_read(a));
    @(posedge clk);
    tk    = m_core | (e2 & ~e3);
    adv   = m_run & tk & ~halt;
    wctrl = sel & wr & (a[3:2] == 2'd0);
    rctrl = sel & ~wr & (a[3:2] == 2'd0);
    wload = sel & wr & (a[3:2] == 2'd1);
    wval  = sel & wr & (a[3:2] == 2'd2);
    start = wctrl & wd[0] & ~m_run;
    zero  = adv & ~wval & (m_cnt == 24'd1);
    if (start)     m_cnt = m_reload;
    else if (wval) m_cnt = '0;
    else if (adv)  m_cnt = exp_step(m_cnt, m_reload);
    if (zero)                m_flag = 1;
    else if (rctrl || wval)  m_flag = 0;
    m_irq = zero & m_ie;
    if (wctrl) begin m_run = wd[0]; m_ie = wd[1]; m_core = wd[2]; end
    if (wload) m_reload = wd[23:0];
    e3 = e2; e2 = e1; e1 = ext;
    @(negedge clk);
    // R5: irq pulse follows the edge that reached zero
    check("R5 irq", {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic idle(int n, logic halt = 0);
    for (int i = 0; i < n; i++) cyc(0, 0, 4'h0, 0, ext_tick, halt, "idle");
  endtask

  task automatic rd(logic [3:0] a, string tag);
    cyc(1, 0, a, 0, ext_tick, dbg_halt, tag);
  endtask

  task automatic wrr(logic [3:0] a, logic [31:0] d);
    cyc(1, 1, a, d, ext_tick, dbg_halt, "write");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R11 R12: reset values and address map
    rd(4'h0, "R1 ctrl");
    rd(4'h4, "R1 load");
    rd(4'h8, "R1 val");
    rd(4'hC, "R11 calib");
    wrr(4'hC, 32'h12345678);
    rd(4'hC, "R11 calib after write");

    // R9 upper bits ignored
    wrr(4'h4, 32'hFF000003);
    rd(4'h4, "R9 load upper bits");

    // R2 R3 R5: enable with interrupts on core clock
    wrr(4'h0, 32'h7);
    rd(4'h8, "R2 loaded value");
    idle(5);
    rd(4'h0, "R4 flag set");
    rd(4'h0, "R4 flag cleared by read");
    rd(4'h8, "R3 count");

    // R6 halt
    idle(4, 1);
    dbg_halt = 1;
    rd(4'h8, "R6 halted count");
    idle(3, 1);
    rd(4'h8, "R6 still halted");
    dbg_halt = 0;

    // R8 value write clears count and flag
    idle(3);
    wrr(4'h8, 32'hAB000000);
    rd(4'h8, "R8 count cleared");
    rd(4'h0, "R8 flag cleared");

    // R9 reserved control bits read zero
    wrr(4'h0, 32'hFFFFFFFF);
    rd(4'h0, "R9 ctrl reserved bits");

    // R10 zero reload
    wrr(4'h4, 32'h0);
    wrr(4'h8, 32'h0);
    idle(20);
    rd(4'h8, "R10 count stays zero");
    rd(4'h0, "R10 flag never set");

    // R7 external tick source
    wrr(4'h4, 32'h4);
    wrr(4'h0, 32'h3);
    for (int k = 0; k < 12; k++) begin
      cyc(0, 0, 4'h0, 0, 1'b1, 0, "ext");
      idle(1 + (k % 3));
      cyc(0, 0, 4'h0, 0, 1'b0, 0, "ext");
      idle(1 + (k % 2));
      rd(4'h8, "R7 ext count");
    end
    rd(4'h0, "R7 ext flag");

    // random mix
    for (int n = 0; n < 6000; n++) begin
      int r;
      logic ext, halt;
      logic [3:0] a;
      r    = $urandom_range(0, 99);
      ext  = ($urandom_range(0, 3) == 0) ? ~ext_tick : ext_tick;
      halt = ($urandom_range(0, 9) == 0);
      a    = {$urandom_range(0, 3), 2'b00};
      if (r < 55)      cyc(0, 0, 4'h0, 0, ext, halt, "rand idle");
      else if (r < 85) cyc(1, 0, a, 0, ext, halt,
                           a == 4'h0 ? "R4 rand ctrl" : a == 4'h4 ? "R9 rand load" :
                           a == 4'h8 ? "R3 rand val" : "R11 rand calib");
      else if (r < 92) cyc(1, 1, 4'h4, {$urandom_range(0, 255), $urandom_range(0, 6)}, ext, halt, "wload");
      else if (r < 97) cyc(1, 1, 4'h0, {$urandom, 29'd0} | $urandom_range(0, 7), ext, halt, "wctrl");
      else             cyc(1, 1, {$urandom_range(2, 3), 2'b00}, $urandom, ext, halt, "wval");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule